// File: doc/BRIEF.md
# HID Report Register Bank with GPIO, S/PDIF Status and Button Events

This block holds the four bytes of an incoming HID output report and assembles the four bytes of the outgoing HID input report. A two-bit mode field in the top bits of output byte 0 decides how the remaining bytes are used. In mode 0, the bytes drive four general-purpose pins (level and direction) and the S/PDIF channel-status fields. In mode 2, the bytes load a mailbox for an external EEPROM controller. Modes 1 and 3 are reserved.

The block also debounces four active-low buttons against a millisecond tick: volume up, volume down, playback mute and record mute. The volume buttons are reported as levels. The two mute buttons raise sticky event flags on release. A record-mute event toggles a mute indicator LED. An interrupt request asks the USB engine to send an input report. It is raised when a button state changes or when the EEPROM controller signals completion, and it clears when the report is read.

Byte k of each report travels on bits [8k+7:8k] of the 32-bit report buses.

Top module: `hid_report_regs`

## Requirements
- R1: After reset, gpio_out, gpio_oe, all S/PDIF and mailbox outputs, ee_wr, irq_req, rec_mute_led and in_report are all zero, so every GPIO is an input.
- R2: A write with byte 0 bits [7:6] = 00 sets gpio_out to byte 1 bits [3:0] (1 = high) and gpio_oe to byte 2 bits [3:0] (1 = drive). Both are visible one cycle after the write.
- R3: A write in mode 00 sets spdif_valid from byte 0 bit 4, spdif_cs_nib from byte 0 bits [3:0] and spdif_cs_cat from byte 3.
- R4: A write with mode 10 loads ee_data0, ee_data1 and ee_ctrl from bytes 1, 2 and 3, and pulses ee_wr for exactly one cycle. The GPIO and S/PDIF outputs are left unchanged.
- R5: A write with mode 01 or 11 changes no GPIO, S/PDIF or mailbox output.
- R6: in_report byte 0 bits [7:6] echo the mode of the last write. In mode 00, in_report byte 1 bits [3:0] show gpio_in two cycles after the pins change, and bytes 2 and 3 read zero.
- R7: In mode 10, in_report bytes 1, 2 and 3 show ee_rdata0, ee_rdata1 and ee_rctrl.
- R8: in_report byte 0 bit 0 and bit 1 show the debounced pressed state of volume-up (btn_n[0]) and volume-down (btn_n[1]).
- R9: A button level is accepted only after it has differed from the accepted level on DEB_TICKS consecutive tick_ms pulses. A shorter glitch is ignored.
- R10: in_report byte 0 bit 2 (playback mute, btn_n[2]) and bit 3 (record mute, btn_n[3]) are set when a debounced press is released. They stay set until a cycle with in_rd clears them.
- R11: Each record-mute event toggles rec_mute_led, which is high while recording is muted.
- R12: irq_req is set by ee_done or by any accepted button change, and is cleared by in_rd. If a set and a read fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond tick for debouncing |
| out_wr | input | 1 | Output report write strobe |
| out_report | input | 32 | Output report bytes 0..3 |
| in_rd | input | 1 | Input report has been read |
| in_report | output | 32 | Input report bytes 0..3 |
| irq_req | output | 1 | Interrupt report pending |
| btn_n | input | 4 | Buttons, active low: vol up, vol down, play mute, rec mute |
| rec_mute_led | output | 1 | Record-mute indicator |
| gpio_in | input | 4 | GPIO pin levels |
| gpio_out | output | 4 | GPIO drive levels |
| gpio_oe | output | 4 | GPIO output enables |
| spdif_valid | output | 1 | S/PDIF validity bit |
| spdif_cs_nib | output | 4 | First channel-status nibble |
| spdif_cs_cat | output | 8 | Channel-status category byte |
| ee_data0 | output | 8 | Mailbox data byte 0 to EEPROM controller |
| ee_data1 | output | 8 | Mailbox data byte 1 to EEPROM controller |
| ee_ctrl | output | 8 | Mailbox control byte to EEPROM controller |
| ee_wr | output | 1 | One-cycle mailbox load strobe |
| ee_done | input | 1 | EEPROM access finished |
| ee_rdata0 | input | 8 | Readback data byte 0 |
| ee_rdata1 | input | 8 | Readback data byte 1 |
| ee_rctrl | input | 8 | Readback control byte |

## Verification
Report writes are registered, so GPIO, S/PDIF, mailbox, mode echo and the ee_wr pulse are all due in the cycle after the write edge. The bench samples them on the falling edge that follows. GPIO inputs pass two synchronizer stages, so the bench waits three falling edges before reading in_report byte 1. Button results come after two synchronizer cycles plus DEB_TICKS ticks. The bench checks both sides of that window: after two tick periods the new level must not yet show, and after a generous margin it must. Sticky flags, the interrupt and the LED update on the edge that accepts an event, and are checked on the falling edge after the read or event cycle.

// File: rtl/hid_rpt_pkg.sv
// Shared constants and types for the HID report register bank.
// Assumes four report bytes of eight bits and four GPIO pins.
package hid_rpt_pkg;
    localparam int RPT_BYTES = 4;
    localparam int RPT_W     = RPT_BYTES * 8;
    localparam int GPIO_N    = 4;
    localparam int BTN_N     = 4;
    localparam int BTN_VUP   = 0;
    localparam int BTN_VDN   = 1;
    localparam int BTN_PMUTE = 2;
    localparam int BTN_RMUTE = 3;

    typedef enum logic [1:0] {
        MODE_GPIO   = 2'd0,
        MODE_RSV_A  = 2'd1,
        MODE_EEPROM = 2'd2,
        MODE_RSV_B  = 2'd3
    } rpt_mode_e;
endpackage

// File: rtl/hid_btn_debounce.sv
// Debounces one active-low button against a millisecond tick.
// Assumes btn_n is asynchronous. Output is the accepted pressed state.
module hid_btn_debounce #(
    parameter int DEB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic pressed
);
    localparam int CNT_W = $clog2(DEB_TICKS + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             raw_pressed;

    // Two-stage synchronizer, reset to the released level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], btn_n};
    end

    assign raw_pressed = ~sync_q[1];

    // Count ticks while the level differs; accept it after DEB_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pressed <= 1'b0;
        end else if (raw_pressed == pressed) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CNT_W'(DEB_TICKS - 1)) begin
                pressed <= raw_pressed;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hid_out_regs.sv
// Decodes output report writes into GPIO, S/PDIF and mailbox registers.
// Assumes wr is a single-cycle strobe. Reserved modes only update mode_q.
module hid_out_regs
    import hid_rpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RPT_W-1:0] data,
    output rpt_mode_e        mode_q,
    output logic [GPIO_N-1:0] gpio_out,
    output logic [GPIO_N-1:0] gpio_oe,
    output logic             spdif_valid,
    output logic [3:0]       spdif_cs_nib,
    output logic [7:0]       spdif_cs_cat,
    output logic [7:0]       ee_data0,
    output logic [7:0]       ee_data1,
    output logic [7:0]       ee_ctrl,
    output logic             ee_wr
);
    rpt_mode_e wr_mode;
    assign wr_mode = rpt_mode_e'(data[7:6]);

    // Register the mode field on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= MODE_GPIO;
        else if (wr) mode_q <= wr_mode;
    end

    // GPIO and S/PDIF fields, loaded only by mode-0 writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_out     <= '0;
            gpio_oe      <= '0;
            spdif_valid  <= 1'b0;
            spdif_cs_nib <= '0;
            spdif_cs_cat <= '0;
        end else if (wr && wr_mode == MODE_GPIO) begin
            gpio_out     <= data[8 +: GPIO_N];
            gpio_oe      <= data[16 +: GPIO_N];
            spdif_valid  <= data[4];
            spdif_cs_nib <= data[3:0];
            spdif_cs_cat <= data[31:24];
        end
    end

    // Mailbox bytes and load strobe, driven only by mode-2 writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_data0 <= '0;
            ee_data1 <= '0;
            ee_ctrl  <= '0;
            ee_wr    <= 1'b0;
        end else begin
            ee_wr <= wr && wr_mode == MODE_EEPROM;
            if (wr && wr_mode == MODE_EEPROM) begin
                ee_data0 <= data[15:8];
                ee_data1 <= data[23:16];
                ee_ctrl  <= data[31:24];
            end
        end
    end
endmodule

// File: rtl/hid_report_regs.sv
// HID report register bank: output report decode, input report assembly,
// button debouncing with sticky events, record-mute LED and interrupt request.
// Assumes in_rd pulses once per input report delivered to the host.
module hid_report_regs
    import hid_rpt_pkg::*;
#(
    parameter int DEB_TICKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_ms,
    input  logic        out_wr,
    input  logic [31:0] out_report,
    input  logic        in_rd,
    output logic [31:0] in_report,
    output logic        irq_req,
    input  logic [3:0]  btn_n,
    output logic        rec_mute_led,
    input  logic [3:0]  gpio_in,
    output logic [3:0]  gpio_out,
    output logic [3:0]  gpio_oe,
    output logic        spdif_valid,
    output logic [3:0]  spdif_cs_nib,
    output logic [7:0]  spdif_cs_cat,
    output logic [7:0]  ee_data0,
    output logic [7:0]  ee_data1,
    output logic [7:0]  ee_ctrl,
    output logic        ee_wr,
    input  logic        ee_done,
    input  logic [7:0]  ee_rdata0,
    input  logic [7:0]  ee_rdata1,
    input  logic [7:0]  ee_rctrl
);
    rpt_mode_e          mode_q;
    logic [BTN_N-1:0]   pressed;
    logic [BTN_N-1:0]   pressed_q;
    logic [GPIO_N-1:0]  gpio_s0, gpio_s1;
    logic               play_flag, rec_flag;
    logic               play_evt, rec_evt, btn_chg;

    hid_out_regs i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (out_wr),
        .data         (out_report),
        .mode_q       (mode_q),
        .gpio_out     (gpio_out),
        .gpio_oe      (gpio_oe),
        .spdif_valid  (spdif_valid),
        .spdif_cs_nib (spdif_cs_nib),
        .spdif_cs_cat (spdif_cs_cat),
        .ee_data0     (ee_data0),
        .ee_data1     (ee_data1),
        .ee_ctrl      (ee_ctrl),
        .ee_wr        (ee_wr)
    );

    for (genvar b = 0; b < BTN_N; b++) begin : g_btn
        hid_btn_debounce #(.DEB_TICKS(DEB_TICKS)) i_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_ms),
            .btn_n   (btn_n[b]),
            .pressed (pressed[b])
        );
    end

    // Previous accepted button state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pressed_q <= '0;
        else        pressed_q <= pressed;
    end

    assign play_evt = pressed_q[BTN_PMUTE] & ~pressed[BTN_PMUTE];
    assign rec_evt  = pressed_q[BTN_RMUTE] & ~pressed[BTN_RMUTE];
    assign btn_chg  = |(pressed ^ pressed_q);

    // Sticky mute events, LED toggle and interrupt request; a set beats a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_flag    <= 1'b0;
            rec_flag     <= 1'b0;
            rec_mute_led <= 1'b0;
            irq_req      <= 1'b0;
        end else begin
            if (play_evt)   play_flag <= 1'b1;
            else if (in_rd) play_flag <= 1'b0;
            if (rec_evt)    rec_flag  <= 1'b1;
            else if (in_rd) rec_flag  <= 1'b0;
            if (rec_evt)    rec_mute_led <= ~rec_mute_led;
            if (ee_done || btn_chg) irq_req <= 1'b1;
            else if (in_rd)         irq_req <= 1'b0;
        end
    end

    // Two-stage synchronizer for GPIO pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_s0 <= '0;
            gpio_s1 <= '0;
        end else begin
            gpio_s0 <= gpio_in;
            gpio_s1 <= gpio_s0;
        end
    end

    // Input report assembly by mode.
    always_comb begin
        in_report        = '0;
        in_report[7:6]   = mode_q;
        in_report[3]     = rec_flag;
        in_report[2]     = play_flag;
        in_report[1]     = pressed[BTN_VDN];
        in_report[0]     = pressed[BTN_VUP];
        unique case (mode_q)
            MODE_GPIO:   in_report[8 +: GPIO_N] = gpio_s1;
            MODE_EEPROM: in_report[31:8] = {ee_rctrl, ee_rdata1, ee_rdata0};
            default:     in_report[31:8] = '0;
        endcase
    end
endmodule

// File: rtl/hid_report_regs_chk.sv
// Property checker for hid_report_regs, attached by bind.
module hid_report_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_wr,
    input logic [31:0] out_report,
    input logic        in_rd,
    input logic [31:0] in_report,
    input logic        irq_req,
    input logic        rec_mute_led,
    input logic [3:0]  gpio_out,
    input logic [3:0]  gpio_oe,
    input logic [7:0]  spdif_cs_cat,
    input logic [7:0]  ee_data0,
    input logic        ee_wr,
    input logic        ee_done
);
    p_oe_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (gpio_oe == 4'h0 && !irq_req && !rec_mute_led));

    p_gpio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(out_wr) && $past(out_report[7:6]) == 2'b00
        |-> (gpio_out == $past(out_report[11:8]) && gpio_oe == $past(out_report[19:16])));

    p_ee_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ee_wr |-> ($past(out_wr) && $past(out_report[7:6]) == 2'b10));

    p_rsv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && out_report[6]) |=> ($stable(gpio_out) && $stable(gpio_oe)
                                       && $stable(ee_data0) && $stable(spdif_cs_cat)));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_report[2]) && !$past(in_rd) |-> in_report[2]);

    p_led_with_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(rec_mute_led) |-> in_report[3]);

    p_irq_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ee_done |=> irq_req);
endmodule

bind hid_report_regs hid_report_regs_chk i_chk (.*);

// File: tb/test_hid_report_regs.sv
// Self-checking bench for hid_report_regs.
module test_hid_report_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 3;

    typedef struct packed {
        logic [31:0] data;
        logic [1:0]  mode;
        logic [3:0]  gout;
        logic [3:0]  goe;
        logic        valid;
        logic [3:0]  nib;
        logic [7:0]  cat;
        logic [23:0] ee;
        logic        eewr;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'hA50F0C1B, 2'd0, 4'hC, 4'hF, 1'b1, 4'hB, 8'hA5, 24'h000000, 1'b0},
        '{32'h56341280, 2'd2, 4'hC, 4'hF, 1'b1, 4'hB, 8'hA5, 24'h563412, 1'b1},
        '{32'hFFFFFF7F, 2'd1, 4'hC, 4'hF, 1'b1, 4'hB, 8'hA5, 24'h563412, 1'b0},
        '{32'hEEEEEEC3, 2'd3, 4'hC, 4'hF, 1'b1, 4'hB, 8'hA5, 24'h563412, 1'b0},
        '{32'h00030500, 2'd0, 4'h5, 4'h3, 1'b0, 4'h0, 8'h00, 24'h563412, 1'b0}
    };

    logic clk = 0, rst_n = 0, tick_ms = 0, out_wr = 0, in_rd = 0, ee_done = 0;
    logic [31:0] out_report = '0;
    logic [3:0]  btn_n = 4'hF, gpio_in = 4'h0;
    logic [7:0]  ee_rdata0 = 0, ee_rdata1 = 0, ee_rctrl = 0;
    logic [31:0] in_report;
    logic        irq_req, rec_mute_led, spdif_valid, ee_wr;
    logic [3:0]  gpio_out, gpio_oe, spdif_cs_nib;
    logic [7:0]  spdif_cs_cat, ee_data0, ee_data1, ee_ctrl;
    logic [1:0]  tdiv = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    hid_report_regs #(.DEB_TICKS(DEB)) i_hid_report_regs (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Millisecond tick stand-in: one pulse every four cycles.
    always @(negedge clk) begin
        tdiv    <= tdiv + 1'b1;
        tick_ms <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_rpt(input logic [31:0] d);
        out_report = d; out_wr = 1;
        cyc(1);
        out_wr = 0;
    endtask

    task automatic rd_rpt();
        in_rd = 1;
        cyc(1);
        in_rd = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 gpio_oe", {28'h0, gpio_oe}, 0);
        chk("R1 gpio_out", {28'h0, gpio_out}, 0);
        chk("R1 in_report", in_report, 0);
        chk("R1 irq/led/ee_wr", {29'h0, irq_req, rec_mute_led, ee_wr}, 0);
        chk("R1 mailbox", {8'h0, ee_ctrl, ee_data1, ee_data0}, 0);

        // Vector walk: R2 R3 R4 R5 and the R6 mode echo
        foreach (VEC[i]) begin
            wr_rpt(VEC[i].data);
            chk("R2 gpio_out", {28'h0, gpio_out}, {28'h0, VEC[i].gout});
            chk("R2 gpio_oe", {28'h0, gpio_oe}, {28'h0, VEC[i].goe});
            chk("R3 spdif", {19'h0, spdif_valid, spdif_cs_nib, spdif_cs_cat},
                {19'h0, VEC[i].valid, VEC[i].nib, VEC[i].cat});
            chk("R4 mailbox", {8'h0, ee_ctrl, ee_data1, ee_data0}, {8'h0, VEC[i].ee});
            chk("R4 ee_wr pulse", {31'h0, ee_wr}, {31'h0, VEC[i].eewr});
            chk("R6 mode echo", {30'h0, in_report[7:6]}, {30'h0, VEC[i].mode});
            cyc(1);
            chk("R4 ee_wr single", {31'h0, ee_wr}, 0);
        end

        // R6 GPIO readback through the synchronizer
        gpio_in = 4'hA;
        cyc(1);
        chk("R6 not yet", {24'h0, in_report[15:8]}, 0);
        cyc(2);
        chk("R6 gpio level", in_report[31:8], 24'h00000A);

        // R7 mailbox readback in mode 2
        ee_rdata0 = 8'h3C; ee_rdata1 = 8'hC3; ee_rctrl = 8'h81;
        wr_rpt(32'h00000080);
        chk("R7 readback", in_report[31:8], 24'h81C33C);
        wr_rpt(32'h00000000);

        // R12 interrupt from ee_done, cleared by read, set wins over read
        ee_done = 1; cyc(1); ee_done = 0;
        chk("R12 irq on done", {31'h0, irq_req}, 1);
        rd_rpt();
        chk("R12 irq cleared", {31'h0, irq_req}, 0);
        ee_done = 1; in_rd = 1; cyc(1); ee_done = 0; in_rd = 0;
        chk("R12 set beats clear", {31'h0, irq_req}, 1);
        rd_rpt();

        // R8 R9 volume-up with debounce window
        btn_n[0] = 0;
        cyc(8);
        chk("R9 not accepted early", {31'h0, in_report[0]}, 0);
        cyc(24);
        chk("R8 vol up pressed", {31'h0, in_report[0]}, 1);
        chk("R12 irq on button", {31'h0, irq_req}, 1);
        btn_n[0] = 1;
        cyc(32);
        chk("R8 vol up released", {31'h0, in_report[0]}, 0);
        rd_rpt();

        // R9 glitch shorter than DEB ticks on volume-down
        btn_n[1] = 0; cyc(4); btn_n[1] = 1;
        cyc(32);
        chk("R9 glitch ignored", {31'h0, in_report[1]}, 0);
        chk("R9 glitch no irq", {31'h0, irq_req}, 0);
        btn_n[1] = 0; cyc(32);
        chk("R8 vol down pressed", {31'h0, in_report[1]}, 1);
        btn_n[1] = 1; cyc(32);
        rd_rpt();

        // R10 playback-mute event on release, sticky until read
        btn_n[2] = 0; cyc(32);
        chk("R10 no flag while held", {31'h0, in_report[2]}, 0);
        btn_n[2] = 1; cyc(32);
        chk("R10 flag after release", {31'h0, in_report[2]}, 1);
        cyc(10);
        chk("R10 flag held", {31'h0, in_report[2]}, 1);
        rd_rpt();
        chk("R10 flag cleared by read", {31'h0, in_report[2]}, 0);

        // R11 record-mute toggles the LED
        btn_n[3] = 0; cyc(32); btn_n[3] = 1; cyc(32);
        chk("R10 rec flag", {31'h0, in_report[3]}, 1);
        chk("R11 led on", {31'h0, rec_mute_led}, 1);
        rd_rpt();
        btn_n[3] = 0; cyc(32); btn_n[3] = 1; cyc(32);
        chk("R11 led off", {31'h0, rec_mute_led}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule